// File: doc/BRIEF.md
# Piecewise-Linear Gamma Corrector

This block reshapes the tone curve of one video channel. Each 10-bit input sample is mapped to an 8-bit output along a curve built from ten straight-line segments. Nine knee values split the input range into the ten segments. Each segment has its own slope and its own base level. A single direction flag sets whether the slope term raises or lowers the output.

A sample is presented with a valid strobe. The block first finds the segment that holds the sample and measures how far the sample lies past the start of that segment. It then scales that distance by the segment slope, adds the slope term to the segment base level or subtracts it, and limits the result to the 8-bit range. Every result appears exactly two clock cycles after its input. Luminance and each colour component use their own instance, each with its own coefficient set.

The coefficient inputs are plain register values supplied by the surrounding logic. They are sampled in the same clock edge as the sample they apply to. A change to the coefficients therefore never splits one sample between an old curve and a new one.

Top module: `pwl_gamma_map`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` is high in exactly the cycles that come two rising edges after a cycle in which `in_valid` was sampled high. No output is produced without an input.
- R3: Knee j (j = 0..8) is `knee_pts[8j+7:8j]` and is compared with `in_sample[9:2]`. The segment index is the number of knees for which `in_sample[9:2] >= knee`. Index 0 starts at input 0. Index s > 0 starts at 4 × knee (s−1).
- R4: The slope of segment s is `slope_regs[8s+7:8s]`, unsigned, with 4 integer and 4 fraction bits. The slope term is floor(slope × (input − segment start) / 16).
- R5: The base level of segment s is `offset_regs[8s+7:8s]`. With `slope_negate` = 0 the slope term is added to the base level; with `slope_negate` = 1 it is subtracted.
- R6: The sum is limited to 0..255. A result below 0 gives 0 and a result above 255 gives 255.
- R7: Coefficients and `slope_negate` are taken in the same clock edge that takes the sample. Changes made after that edge do not affect that sample's result.
- R8: While `out_valid` is low, `out_sample` keeps its last value, whatever the coefficient inputs do.
- R9: When knees are equal, the segment between them is empty. An input at or above the shared value uses the higher segment index, and that segment starts at 4 × the shared value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 10 | Input video sample |
| knee_pts | input | 72 | Nine 8-bit knee values, knee 0 in the low byte |
| slope_regs | input | 80 | Ten 8-bit slopes (4.4 unsigned), segment 0 in the low byte |
| offset_regs | input | 80 | Ten 8-bit base levels, segment 0 in the low byte |
| slope_negate | input | 1 | 0 adds the slope term, 1 subtracts it |
| out_valid | output | 1 | Output qualifier, two cycles after the input |
| out_sample | output | 8 | Corrected, saturated output sample |

## Verification
The properties assume that `in_valid` and the coefficient inputs are known, 0 or 1, on every rising edge after reset. The bound on the output relative to the base level holds only for a segment chosen from knees in non-decreasing order. The bench drives every input on the falling clock edge, so each input is settled when the rising edge samples it. Every knee set it uses is non-decreasing, including the set with two equal knees.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;
    localparam int SAMPLE_W = 10;                 // input sample width
    localparam int OUT_W    = 8;                  // output sample width
    localparam int COEF_W   = 8;                  // knee, slope and base width
    localparam int NUM_SEG  = 10;                 // straight-line segments
    localparam int FRAC_W   = 4;                  // slope fraction bits

    localparam int NUM_KNEE = NUM_SEG - 1;
    localparam int SEG_W    = $clog2(NUM_SEG);
    localparam int LOW_W    = SAMPLE_W - COEF_W;  // input bits below a knee
    localparam int PROD_W   = COEF_W + SAMPLE_W;
    localparam int MAG_W    = PROD_W - FRAC_W;
    localparam int ACC_W    = MAG_W + 2;
endpackage

// File: rtl/pwl_seg_select.sv
// Stage 1: find the segment, take its coefficients with the sample.
module pwl_seg_select
    import pwl_gamma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [SAMPLE_W-1:0]        in_sample,
    input  logic [NUM_KNEE*COEF_W-1:0] knee_pts,
    input  logic [NUM_SEG*COEF_W-1:0]  slope_regs,
    input  logic [NUM_SEG*COEF_W-1:0]  offset_regs,
    input  logic                       slope_negate,
    output logic                       s1_valid,
    output logic [COEF_W-1:0]          s1_slope,
    output logic [COEF_W-1:0]          s1_offset,
    output logic [SAMPLE_W-1:0]        s1_dist,
    output logic                       s1_negate
);
    logic [COEF_W-1:0]   start_tab  [NUM_SEG];
    logic [COEF_W-1:0]   slope_tab  [NUM_SEG];
    logic [COEF_W-1:0]   offset_tab [NUM_SEG];
    logic [NUM_KNEE-1:0] knee_hit;
    logic [COEF_W-1:0]   coarse;
    logic [SEG_W-1:0]    seg_idx;
    logic [SAMPLE_W-1:0] seg_start;
    logic [SAMPLE_W-1:0] seg_dist;

    assign coarse       = in_sample[SAMPLE_W-1 -: COEF_W];
    assign start_tab[0] = '0;

    generate
        for (genvar k = 0; k < NUM_KNEE; k++) begin : g_knee
            assign start_tab[k+1] = knee_pts[k*COEF_W +: COEF_W];
            assign knee_hit[k]    = (coarse >= start_tab[k+1]);
        end
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_coef
            assign slope_tab[s]  = slope_regs[s*COEF_W +: COEF_W];
            assign offset_tab[s] = offset_regs[s*COEF_W +: COEF_W];
        end
    endgenerate

    // Segment index = number of knees at or below the sample.
    always_comb begin
        seg_idx = '0;
        for (int k = 0; k < NUM_KNEE; k++) begin
            seg_idx = seg_idx + SEG_W'(knee_hit[k]);
        end
    end

    assign seg_start = {start_tab[seg_idx], {LOW_W{1'b0}}};
    assign seg_dist  = in_sample - seg_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_slope  <= '0;
            s1_offset <= '0;
            s1_dist   <= '0;
            s1_negate <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_slope  <= slope_tab[seg_idx];
                s1_offset <= offset_tab[seg_idx];
                s1_dist   <= seg_dist;
                s1_negate <= slope_negate;
            end
        end
    end
endmodule

// File: rtl/pwl_seg_eval.sv
// Stage 2: scale, add or subtract, saturate.
module pwl_seg_eval
    import pwl_gamma_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s1_valid,
    input  logic [COEF_W-1:0]   s1_slope,
    input  logic [COEF_W-1:0]   s1_offset,
    input  logic [SAMPLE_W-1:0] s1_dist,
    input  logic                s1_negate,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_sample
);
    localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << OUT_W) - 1);

    logic [PROD_W-1:0]       product;
    logic [MAG_W-1:0]        magnitude;
    logic signed [ACC_W-1:0] base_ext;
    logic signed [ACC_W-1:0] mag_ext;
    logic signed [ACC_W-1:0] acc;
    logic [OUT_W-1:0]        limited;

    assign product   = PROD_W'(s1_slope) * PROD_W'(s1_dist);
    assign magnitude = product[PROD_W-1:FRAC_W];
    assign base_ext  = ACC_W'(s1_offset);
    assign mag_ext   = ACC_W'(magnitude);
    assign acc       = s1_negate ? (base_ext - mag_ext) : (base_ext + mag_ext);

    always_comb begin
        if (acc < 0) begin
            limited = '0;
        end else if (acc > OUT_MAX) begin
            limited = '1;
        end else begin
            limited = acc[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_sample <= limited;
            end
        end
    end
endmodule

// File: rtl/pwl_gamma_map.sv
module pwl_gamma_map
    import pwl_gamma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [SAMPLE_W-1:0]        in_sample,
    input  logic [NUM_KNEE*COEF_W-1:0] knee_pts,
    input  logic [NUM_SEG*COEF_W-1:0]  slope_regs,
    input  logic [NUM_SEG*COEF_W-1:0]  offset_regs,
    input  logic                       slope_negate,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           out_sample
);
    logic                s1_valid;
    logic [COEF_W-1:0]   s1_slope;
    logic [COEF_W-1:0]   s1_offset;
    logic [SAMPLE_W-1:0] s1_dist;
    logic                s1_negate;

    pwl_seg_select u_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sample    (in_sample),
        .knee_pts     (knee_pts),
        .slope_regs   (slope_regs),
        .offset_regs  (offset_regs),
        .slope_negate (slope_negate),
        .s1_valid     (s1_valid),
        .s1_slope     (s1_slope),
        .s1_offset    (s1_offset),
        .s1_dist      (s1_dist),
        .s1_negate    (s1_negate)
    );

    pwl_seg_eval u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_slope   (s1_slope),
        .s1_offset  (s1_offset),
        .s1_dist    (s1_dist),
        .s1_negate  (s1_negate),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/pwl_gamma_chk.sv
module pwl_gamma_chk
    import pwl_gamma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              s1_valid,
    input logic [COEF_W-1:0] s1_offset,
    input logic              s1_negate,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_sample
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R2: two-cycle latency, valid follows input valid
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8: output held while not valid
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc >= 2'd1) && !out_valid) |-> $stable(out_sample));

    // R5: adding never goes below the base level
    a_r5_add_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_negate) |=> (out_sample >= $past(s1_offset)));

    // R5: subtracting never goes above the base level
    a_r5_sub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_negate) |=> (out_sample <= $past(s1_offset)));
endmodule

bind pwl_gamma_map pwl_gamma_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .s1_valid   (s1_valid),
    .s1_offset  (s1_offset),
    .s1_negate  (s1_negate),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/pwl_gamma_map_bench.sv
`timescale 1ns/1ps
module pwl_gamma_map_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_sample = '0;
    logic [71:0] knee_pts;
    logic [79:0] slope_regs;
    logic [79:0] offset_regs;
    logic        slope_negate = 1'b0;
    logic        out_valid;
    logic [7:0]  out_sample;

    logic [7:0] kb [9];
    logic [7:0] sl [10];
    logic [7:0] of [10];

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 9; k++) knee_pts[k*8 +: 8] = kb[k];
        for (int s = 0; s < 10; s++) begin
            slope_regs[s*8 +: 8]  = sl[s];
            offset_regs[s*8 +: 8] = of[s];
        end
    end

    pwl_gamma_map u_pwl_gamma_map (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .knee_pts(knee_pts), .slope_regs(slope_regs), .offset_regs(offset_regs),
        .slope_negate(slope_negate), .out_valid(out_valid), .out_sample(out_sample)
    );

    // {sample, expected} with the default curve, slope added
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {10'd0,    8'd0},   {10'd10,   8'd40},  {10'd63,  8'd252},
        {10'd64,   8'd120}, {10'd100,  8'd192}, {10'd127, 8'd246},
        {10'd128,  8'd150}, {10'd129,  8'd151}, {10'd137, 8'd163},
        {10'd191,  8'd244}, {10'd192,  8'd170}, {10'd250, 8'd228},
        {10'd300,  8'd218}, {10'd383,  8'd255}, {10'd385, 8'd200},
        {10'd500,  8'd255}, {10'd600,  8'd248}, {10'd700, 8'd240},
        {10'd800,  8'd241}, {10'd900,  8'd245}, {10'd1023, 8'd255},
        {10'd130,  8'd153}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        kb = '{8'd16, 8'd32, 8'd48, 8'd64, 8'd96, 8'd128, 8'd160, 8'd192, 8'd224};
        sl = '{8'h40, 8'h20, 8'h18, 8'h10, 8'h0C, 8'h08, 8'h06, 8'h04, 8'h03, 8'h02};
        of = '{8'd0, 8'd120, 8'd150, 8'd170, 8'd185, 8'd200, 8'd215, 8'd225, 8'd235, 8'd245};
        slope_negate = 1'b0;
    endtask

    // Sample driven at a falling edge; result read two falling edges later.
    task automatic send_one(input logic [9:0] smp, input int exp, input string req);
        in_valid  = 1'b1;
        in_sample = smp;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_sample), exp);
    endtask

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset sample", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Streaming walk through the table: R3 R4 R6
        for (int j = 0; j < NV + 2; j++) begin
            if (j >= 2) begin
                check("R2 stream valid", int'(out_valid), 1);
                check($sformatf("R3/R4/R6 sample %0d", VEC[j-2][17:8]),
                      int'(out_sample), int'(VEC[j-2][7:0]));
            end
            if (j < NV) begin
                in_valid  = 1'b1;
                in_sample = VEC[j][17:8];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R8: hold while idle, coefficient churn has no effect
        of[9] = 8'd0;
        sl[9] = 8'hFF;
        slope_negate = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 idle valid", int'(out_valid), 0);
        check("R8 hold", int'(out_sample), 153);
        set_defaults();

        // R2: exact latency for a lone sample
        in_valid = 1'b1;
        in_sample = 10'd100;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 one edge", int'(out_valid), 0);
        @(negedge clk);
        check("R2 two edges", int'(out_valid), 1);
        check("R2 value", int'(out_sample), 192);
        @(negedge clk);
        check("R2 single pulse", int'(out_valid), 0);

        // R5 subtract, R6 low clamp
        slope_negate = 1'b1;
        send_one(10'd100, 48, "R5 subtract seg1");
        send_one(10'd250, 112, "R5 subtract seg3");
        send_one(10'd127, 0, "R6 clamp low");
        send_one(10'd10, 0, "R6 clamp low seg0");
        slope_negate = 1'b0;

        // R7: change right after capture does not affect the sample
        in_valid = 1'b1;
        in_sample = 10'd100;
        @(negedge clk);
        in_valid = 1'b0;
        of[1] = 8'd0;
        slope_negate = 1'b1;
        @(negedge clk);
        check("R7 old coefficients", int'(out_sample), 192);
        slope_negate = 1'b0;
        send_one(10'd100, 72, "R7 new coefficients");
        set_defaults();

        // R9: equal knees skip the empty segment
        kb[2] = 8'd32;
        send_one(10'd130, 172, "R9 equal knees");
        send_one(10'd129, 171, "R9 equal knees low");
        send_one(10'd127, 246, "R9 below shared knee");
        set_defaults();

        // R1: reset during operation clears output
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", int'(out_valid), 0);
        check("R1 mid reset sample", int'(out_sample), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule